// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register set of a single DMA channel inside an older I/O controller. It has four 32-bit registers: control/status, memory address, byte count and a test/base word. They are reached through a simple slave port that takes whole words only. The block does not move data. Its job is to present channel state to the CPU and drive control lines toward the attached peripheral, namely a one-clock reset strobe and a level enable. It also passes the peripheral's interrupt request on to the CPU when software has enabled it.

The peripheral reports each completed transfer together with its length in bytes, and the block advances the address register by that amount. A write to the address register marks it as loaded in the status word. The control/status word has a fixed version field and a set of read-only bits. It also has a drain-bit behaviour: writing a drain request clears the bit, and writing an all-zero word sets it.

One parameter selects the decode window. The standard variant decodes 16 bytes and folds every offset into them. The network variant decodes 32 bytes: its upper 16 bytes repeat the registers, and every offset past the window is dead.

Top module: `dma_chan_regs`

## Requirements
- R1: A bus access is taken only when `busSel` is high and all four bits of `busByteEn` are set. Register index is `busAddr[3:2]`: 0 control/status, 1 address, 2 count, 3 test. A refused access writes nothing, and a refused read returns zero. `busRdata` is zero whenever no read is taken.
- R2: After reset the control/status register reads 0xA0000000 and the other three registers read zero.
- R3: In a control/status write, the bits under mask 0xFE000007 keep their stored value. The version pattern 0xA0000000 always reads back set.
- R4: Control/status bit 0 (pending) holds the level of `periphIrq` as sampled at the previous clock edge.
- R5: `cpuIrq` is high exactly while bit 0 (pending) and bit 4 (interrupt enable) of the stored control/status are both 1.
- R6: A taken control/status write with data bit 7 set makes `periphRst` high for the single following cycle. Bit 7 is stored and reads back as written.
- R7: In a control/status write with bit 7 clear, a set bit 6 is stored as 0. An all-zero write value stores bit 6 as 1.
- R8: `chanEn` equals the stored control/status bit 9. It rises after a write that sets bit 9 and falls after a write that clears it.
- R9: A taken write to the address register also sets control/status bit 26 (loaded). The bit is read-only and stays set until reset.
- R10: When `xferValid` is high, the address register grows by `xferLen` (wrapping modulo 2^32). A bus write to the address register in the same cycle wins over the increment.
- R11: With `NET_WINDOW`=1, offsets 0x10 to 0x1F alias the registers, and offsets above 0x1F read zero and ignore writes. With `NET_WINDOW`=0, every offset aliases through its low four bits.
- R12: The count and test registers store any 32-bit value written and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset into the block |
| busByteEn | input | 4 | Byte lanes; all four required |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle as the request |
| periphIrq | input | 1 | Level interrupt request from the peripheral |
| xferValid | input | 1 | Peripheral reports a completed transfer |
| xferLen | input | LEN_W | Byte count of the reported transfer |
| cpuIrq | output | 1 | Gated interrupt to the CPU |
| periphRst | output | 1 | One-clock reset strobe to the peripheral |
| chanEn | output | 1 | Channel enable level |

## Verification
The bench builds two copies side by side from the same stimulus, one with `NET_WINDOW`=1 and one with `NET_WINDOW`=0, each with `ADDR_W`=8 so that offsets well past 0x1F can be driven. Running both together shows the difference directly. An offset such as 0x28 is dropped by the network copy but lands on the count register of the standard copy. Offsets 0x10 to 0x1F fold onto the same four registers in both copies. `LEN_W`=16 lets a single report of up to 0xFFFF bytes push the address across its 32-bit wrap.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] VERSION_TAG = 32'hA000_0000;
  localparam logic [DATA_W-1:0] RO_MASK     = 32'hFE00_0007;

  localparam int PEND_BIT   = 0;
  localparam int IEN_BIT    = 4;
  localparam int DRAIN_BIT  = 6;
  localparam int PRST_BIT   = 7;
  localparam int DIR_BIT    = 8;
  localparam int EN_BIT     = 9;
  localparam int LOADED_BIT = 26;

  typedef enum logic [1:0] {
    REG_CSR   = 2'd0,
    REG_ADDR  = 2'd1,
    REG_COUNT = 2'd2,
    REG_TEST  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCsr;
    logic    wrAddr;
    logic    wrCount;
    logic    wrTest;
    logic    rdEn;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/dma_chan_regs_ctrl.sv
module dma_chan_regs_ctrl
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit NET_WINDOW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic              wdataRstBit,
  output strobe_t           strb,
  output logic              periphRst
);

  localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(31);

  logic    inWindow;
  logic    fullWord;
  logic    accept;
  regSel_e sel;
  logic    unusedAddrBits;

  // Window check: the wide variant drops offsets past its last byte,
  // the narrow one folds everything through the low nibble.
  if (NET_WINDOW) begin : g_netWin
    assign inWindow = (busAddr <= WIN_LAST);
  end else begin : g_stdWin
    assign inWindow = 1'b1;
  end

  assign unusedAddrBits = ^{busAddr[ADDR_W-1:4], busAddr[1:0]};

  assign fullWord = &busByteEn;
  assign accept   = busSel && fullWord && inWindow;
  assign sel      = regSel_e'(busAddr[3:2]);

  always_comb begin
    strb         = '0;
    strb.rdSel   = sel;
    strb.rdEn    = accept && !busWr;
    strb.wrCsr   = accept && busWr && (sel == REG_CSR);
    strb.wrAddr  = accept && busWr && (sel == REG_ADDR);
    strb.wrCount = accept && busWr && (sel == REG_COUNT);
    strb.wrTest  = accept && busWr && (sel == REG_TEST);
  end

  // Reset strobe: one clock, issued after the control write that asks for it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periphRst <= 1'b0;
    else       periphRst <= strb.wrCsr && wdataRstBit;
  end

endmodule

// File: rtl/dma_chan_regs_dpath.sv
module dma_chan_regs_dpath
  import dma_chan_regs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              periphIrq,
  input  logic              xferValid,
  input  logic [LEN_W-1:0]  xferLen,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] csrQ,
  output logic [DATA_W-1:0] addrQ,
  output logic              cpuIrq,
  output logic              chanEn
);

  logic [DATA_W-1:0] countQ, testQ;
  logic [DATA_W-1:0] csrNext, addrNext;

  // Drain-bit rule applied to an incoming control word.
  function automatic logic [DATA_W-1:0] shapeCtl(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = v;
    if (!v[PRST_BIT]) begin
      if (v[DRAIN_BIT])  r[DRAIN_BIT] = 1'b0;
      else if (v == '0)  r[DRAIN_BIT] = 1'b1;
    end
    return r;
  endfunction

  always_comb begin
    csrNext = csrQ;
    if (strb.wrCsr)
      csrNext = (csrQ & RO_MASK) | (shapeCtl(busWdata) & ~RO_MASK) | VERSION_TAG;
    if (strb.wrAddr)
      csrNext[LOADED_BIT] = 1'b1;
    csrNext[PEND_BIT] = periphIrq;
  end

  always_comb begin
    addrNext = addrQ;
    if (strb.wrAddr)    addrNext = busWdata;
    else if (xferValid) addrNext = addrQ + DATA_W'(xferLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrQ   <= VERSION_TAG;
      addrQ  <= '0;
      countQ <= '0;
      testQ  <= '0;
    end else begin
      csrQ  <= csrNext;
      addrQ <= addrNext;
      if (strb.wrCount) countQ <= busWdata;
      if (strb.wrTest)  testQ  <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        REG_CSR:   busRdata = csrQ;
        REG_ADDR:  busRdata = addrQ;
        REG_COUNT: busRdata = countQ;
        REG_TEST:  busRdata = testQ;
        default:   busRdata = '0;
      endcase
    end
  end

  assign cpuIrq = csrQ[PEND_BIT] && csrQ[IEN_BIT];
  assign chanEn = csrQ[EN_BIT];

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 16,
  parameter bit NET_WINDOW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              periphIrq,
  input  logic              xferValid,
  input  logic [LEN_W-1:0]  xferLen,
  output logic              cpuIrq,
  output logic              periphRst,
  output logic              chanEn
);

  strobe_t           strb;
  logic [DATA_W-1:0] csrQ;
  logic [DATA_W-1:0] addrQ;

  dma_chan_regs_ctrl #(
    .ADDR_W    (ADDR_W),
    .NET_WINDOW(NET_WINDOW)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busByteEn  (busByteEn),
    .wdataRstBit(busWdata[PRST_BIT]),
    .strb       (strb),
    .periphRst  (periphRst)
  );

  dma_chan_regs_dpath #(
    .LEN_W(LEN_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .periphIrq(periphIrq),
    .xferValid(xferValid),
    .xferLen  (xferLen),
    .busRdata (busRdata),
    .csrQ     (csrQ),
    .addrQ    (addrQ),
    .cpuIrq   (cpuIrq),
    .chanEn   (chanEn)
  );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_regs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       busWdata,
  input logic              periphIrq,
  input logic              xferValid,
  input logic [LEN_W-1:0]  xferLen,
  input logic              cpuIrq,
  input logic              periphRst,
  input logic              chanEn,
  input strobe_t           strb,
  input logic [DATA_W-1:0] csrQ,
  input logic [DATA_W-1:0] addrQ
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_VERSION_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    csrQ[31] && !csrQ[30] && csrQ[29]);                                     // R3

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (csrQ[PEND_BIT] == $past(periphIrq)));                    // R4

  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && cpuIrq) |-> $past(periphIrq));                            // R5

  AST_RST_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && periphRst) |-> $past(strb.wrCsr && busWdata[PRST_BIT]));  // R6

  AST_EN_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(chanEn)) |-> $past(strb.wrCsr && busWdata[EN_BIT])); // R8

  AST_LOADED_SET: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strb.wrAddr)) |-> csrQ[LOADED_BIT]);                // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(xferValid && !strb.wrAddr))
      |-> (addrQ == $past(addrQ) + DATA_W'($past(xferLen))));               // R10

endmodule

bind dma_chan_regs dma_chan_regs_chk #(
  .LEN_W(LEN_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busWdata (busWdata),
  .periphIrq(periphIrq),
  .xferValid(xferValid),
  .xferLen  (xferLen),
  .cpuIrq   (cpuIrq),
  .periphRst(periphRst),
  .chanEn   (chanEn),
  .strb     (strb),
  .csrQ     (csrQ),
  .addrQ    (addrQ)
);

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;

  localparam int PERIOD = 10;
  localparam int AW     = 8;
  localparam int LW     = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bSel = 1'b0, bWr = 1'b0;
  logic [AW-1:0] bAddr = '0;
  logic [3:0]    bBe = '0;
  logic [31:0]   bWdata = '0;
  logic          pIrq = 1'b0;
  logic          xV = 1'b0;
  logic [LW-1:0] xLen = '0;

  logic [31:0] rdNet, rdStd;
  logic        irqNet, irqStd, prNet, prStd, enNet, enStd;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dma_chan_regs #(.ADDR_W(AW), .LEN_W(LW), .NET_WINDOW(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(bSel), .busWr(bWr), .busAddr(bAddr),
    .busByteEn(bBe), .busWdata(bWdata), .busRdata(rdNet), .periphIrq(pIrq),
    .xferValid(xV), .xferLen(xLen), .cpuIrq(irqNet), .periphRst(prNet),
    .chanEn(enNet));

  dma_chan_regs #(.ADDR_W(AW), .LEN_W(LW), .NET_WINDOW(1'b0)) dutStd_i (
    .clk(clk), .rstN(rstN), .busSel(bSel), .busWr(bWr), .busAddr(bAddr),
    .busByteEn(bBe), .busWdata(bWdata), .busRdata(rdStd), .periphIrq(pIrq),
    .xferValid(xV), .xferLen(xLen), .cpuIrq(irqStd), .periphRst(prStd),
    .chanEn(enStd));

  // Reference state: [variant][register]; variant 0 = wide window, 1 = narrow.
  logic [31:0] mReg [2][4];
  bit          mPulse [2];

  function automatic bit taken(int v);
    return bSel && (bBe == 4'hF) && (v == 1 || bAddr <= 8'h1F);
  endfunction

  function automatic logic [31:0] expRd(int v);
    if (taken(v) && !bWr) return mReg[v][bAddr[3:2]];
    return 32'h0;
  endfunction

  task automatic modelReset();
    for (int v = 0; v < 2; v++) begin
      mReg[v][0] = 32'hA000_0000;
      for (int r = 1; r < 4; r++) mReg[v][r] = 32'h0;
      mPulse[v] = 1'b0;
    end
  endtask

  task automatic modelEdge();
    for (int v = 0; v < 2; v++) begin
      bit          w = taken(v) && bWr;
      int          idx = int'(bAddr[3:2]);
      logic [31:0] c = mReg[v][0];
      logic [31:0] d = bWdata;
      mPulse[v] = w && idx == 0 && bWdata[7];
      if (w && idx == 0) begin
        if (!d[7]) begin
          if (d[6]) d[6] = 1'b0;
          else if (d == 32'h0) d[6] = 1'b1;
        end
        c = (c & 32'hFE00_0007) | (d & ~32'hFE00_0007) | 32'hA000_0000;
      end
      if (w && idx == 1) begin
        mReg[v][1] = bWdata;
        c[26] = 1'b1;
      end else if (xV) begin
        mReg[v][1] = mReg[v][1] + 32'(xLen);
      end
      if (w && idx >= 2) mReg[v][idx] = bWdata;
      c[0] = pIrq;
      mReg[v][0] = c;
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Inputs are already set (after a falling edge); check just before the
  // rising edge, then let the model take the same edge.
  task automatic cyc(string tag);
    #(PERIOD/2 - 1);
    chk(tag,  "net rdata", rdNet, expRd(0));
    chk(tag,  "std rdata", rdStd, expRd(1));
    chk("R5", "net cpuIrq", 32'(irqNet), 32'(mReg[0][0][0] & mReg[0][0][4]));
    chk("R5", "std cpuIrq", 32'(irqStd), 32'(mReg[1][0][0] & mReg[1][0][4]));
    chk("R6", "net periphRst", 32'(prNet), 32'(mPulse[0]));
    chk("R6", "std periphRst", 32'(prStd), 32'(mPulse[1]));
    chk("R8", "net chanEn", 32'(enNet), 32'(mReg[0][0][9]));
    chk("R8", "std chanEn", 32'(enStd), 32'(mReg[1][0][9]));
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic setBus(bit s, bit w, logic [AW-1:0] a, logic [3:0] be, logic [31:0] d);
    bSel = s; bWr = w; bAddr = a; bBe = be; bWdata = d; xV = 1'b0; xLen = '0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    setBus(1'b1, 1'b1, a, 4'hF, d);
    cyc(tag);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    setBus(1'b1, 1'b0, a, 4'hF, 32'h0);
    cyc(tag);
  endtask

  task automatic idle(string tag);
    setBus(1'b0, 1'b0, '0, 4'h0, 32'h0);
    cyc(tag);
  endtask

  task automatic xfer(logic [LW-1:0] n, string tag);
    setBus(1'b0, 1'b0, '0, 4'h0, 32'h0);
    xV = 1'b1; xLen = n;
    cyc(tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset values
    rd(8'h00, "R2"); rd(8'h04, "R2"); rd(8'h08, "R2"); rd(8'h0C, "R2");
    // R7: drain quirk
    wr(8'h00, 32'h0, "R7");         rd(8'h00, "R7");
    wr(8'h00, 32'h40, "R7");        rd(8'h00, "R7");
    wr(8'h00, 32'h140, "R7");       rd(8'h00, "R7");
    // R6: reset strobe, bit 7 kept with bit 6
    wr(8'h00, 32'hC0, "R6");        rd(8'h00, "R6");
    wr(8'h00, 32'h80, "R6");        wr(8'h00, 32'h80, "R6"); rd(8'h00, "R6");
    // R3: read-only mask and version
    wr(8'h00, 32'hFFFF_FFFF, "R3"); rd(8'h00, "R3");
    // R4 / R5: pending follows input, gated by enable
    pIrq = 1'b1; idle("R4"); rd(8'h00, "R4");
    wr(8'h00, 32'h200, "R5");       rd(8'h00, "R5");
    wr(8'h00, 32'h210, "R5");       idle("R5");
    pIrq = 1'b0; idle("R4"); rd(8'h00, "R4");
    // R8: enable falls
    wr(8'h00, 32'h10, "R8");        rd(8'h00, "R8");
    // R9: loaded bit
    wr(8'h04, 32'h0000_1000, "R9"); rd(8'h00, "R9"); rd(8'h04, "R9");
    // R10: increments, wrap, bus write wins
    xfer(16'h0010, "R10"); xfer(16'hFFFF, "R10"); rd(8'h04, "R10");
    wr(8'h04, 32'hFFFF_FFF0, "R10"); xfer(16'h0020, "R10"); rd(8'h04, "R10");
    setBus(1'b1, 1'b1, 8'h04, 4'hF, 32'h0000_0500); xV = 1'b1; xLen = 16'h0008;
    cyc("R10"); rd(8'h04, "R10");
    // R12: plain registers
    wr(8'h08, 32'hDEAD_BEEF, "R12"); wr(8'h0C, 32'h1234_5678, "R12");
    rd(8'h08, "R12"); rd(8'h0C, "R12");
    // R1: partial lanes refused, unselected bus reads zero
    setBus(1'b1, 1'b1, 8'h08, 4'h3, 32'h5555_5555); cyc("R1");
    rd(8'h08, "R1");
    setBus(1'b1, 1'b0, 8'h08, 4'h7, 32'h0); cyc("R1");
    setBus(1'b0, 1'b0, 8'h08, 4'hF, 32'h0); cyc("R1");
    // R11: aliasing and dead offsets
    wr(8'h18, 32'hAAAA_0001, "R11"); rd(8'h08, "R11"); rd(8'h1C, "R11");
    wr(8'h28, 32'hBBBB_0002, "R11"); rd(8'h08, "R11"); rd(8'h28, "R11");
    wr(8'hF4, 32'h0000_0777, "R11"); rd(8'h04, "R11"); rd(8'hF0, "R11");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      setBus(seed[20], seed[21], seed[29:22], seed[19:18] == 2'b00 ? 4'h1 : 4'hF,
             {seed[15:0], seed[30:15]});
      xV = seed[8]; xLen = LW'(seed[14:3]);
      pIrq = seed[2];
      cyc("R1");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule